// File: doc/BRIEF.md
# Channel-Aligned Audio Sample FIFO

This block buffers audio samples for one direction of a serial audio port. One side is a small register interface used by software or a bus master; the other side is a serializer that moves one sample word per request. In the transmit build the bus fills the FIFO through its data register and the serializer drains it. In the receive build the serializer fills it and the bus drains it through the same data register.

Usable depth is not fixed. A three-bit size code selects the word capacity (256 words shifted left by the code, limited by the physical RAM). The active channel count is rounded up to a power of two, and that slot width divides the word capacity to give the frame capacity. Channel counts of 3, 5, 6 and 7 leave part of the RAM unused. A frame count, two sticky error flags and a half-level interrupt tell software when to service the FIFO.

Top module: `audio_sample_fifo`

## Requirements
- R1: Frame capacity equals min(256 << cfg_size, 2**RAM_AW) words divided by the channel count (cfg_chans_m1 + 1) rounded up to a power of two; word capacity is that frame capacity times the channel count, and pushes beyond it are refused.
- R2: Register 1 (status) reports in bits 16:8 the number of complete frames stored, saturating at 511; a frame counts once its last channel word has been pushed and stops counting once its last channel word has been popped.
- R3: A push while full discards the word, leaves the stored content unchanged and sets the sticky overrun flag in status bit 4.
- R4: A pop while empty returns zero, moves nothing and sets the sticky underrun flag in status bit 0.
- R5: Each flag stays set until a status write carries 0 in its bit; a write carrying 1 keeps it. An error event in the same cycle as a clearing write leaves the flag set.
- R6: Writing register 0 (control) with bit 0 set empties the FIFO at that clock edge, overriding a serializer push or pop in the same cycle; the error flags keep their values and control bit 0 always reads 0.
- R7: Control bit 20 enables half_irq. In the transmit build half_irq is high while the frame count is at or below half the frame capacity; in the receive build while it is at or above half.
- R8: Only bits 23:0 of a data word are stored; bits 31:24 of a bus write are dropped and read back as zero; words leave in the order they entered.
- R9: Register 2 (data) pushes on write in the transmit build and pops on read in the receive build; a data read in the transmit build returns zero and a data write in the receive build is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_size | input | 3 | RAM size code, word capacity 256 << code |
| cfg_chans_m1 | input | 3 | Active channel count minus one |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops in receive build) |
| reg_addr | input | 2 | Register index: 0 control, 1 status, 2 data |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the strobe cycle |
| ser_req | input | 1 | Serializer push (receive) or pop (transmit) request |
| ser_wdata | input | 24 | Serializer push data |
| ser_rdata | output | 24 | Serializer pop data, valid in the request cycle |
| half_irq | output | 1 | Half-level interrupt |

## Verification
Two pairs of functions can meet in one clock. A clear written by the bus can coincide with a serializer push; the bench issues both on the same edge of the receive build and judges the outcome by a zero frame count and an empty data pop afterwards. A status write that clears the underrun flag can coincide with a serializer pop on an empty transmit FIFO; the bench fires both together and expects the flag to read back set.

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo #(
  parameter int RAM_AW = 9,
  parameter bit IS_TX  = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_size,
  input  logic [2:0]  cfg_chans_m1,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ser_req,
  input  logic [23:0] ser_wdata,
  output logic [23:0] ser_rdata,
  output logic        half_irq
);

  localparam int DEPTH = 2 ** RAM_AW;
  localparam int CW    = RAM_AW + 1;

  logic [23:0]       mem [DEPTH];
  logic [RAM_AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0]     word_cnt, frm_cnt;
  logic [2:0]        wcol, rcol;
  logic              ovr, udr, irq_en;

  logic [1:0]    slot_sh;
  logic [4:0]    sum_log, words_log, frame_log;
  logic [CW-1:0] frame_cap, chans, cap_words, half;

  always_comb begin
    case (cfg_chans_m1)
      3'd0:        slot_sh = 2'd0;
      3'd1:        slot_sh = 2'd1;
      3'd2, 3'd3:  slot_sh = 2'd2;
      default:     slot_sh = 2'd3;
    endcase
  end

  assign sum_log   = 5'(cfg_size) + 5'd8;
  assign words_log = (sum_log > 5'(RAM_AW)) ? 5'(RAM_AW) : sum_log;
  assign frame_log = words_log - 5'(slot_sh);
  assign frame_cap = CW'(1) << frame_log;
  assign chans     = CW'(cfg_chans_m1) + CW'(1);
  assign cap_words = frame_cap * chans;
  assign half      = frame_cap >> 1;

  logic full, empty;
  assign full  = (word_cnt == cap_words);
  assign empty = (word_cnt == '0);

  logic bus_dwr, bus_drd, clr, st_wr, ctl_wr;
  assign bus_dwr = reg_wr && reg_addr == 2'd2;
  assign bus_drd = reg_rd && reg_addr == 2'd2;
  assign ctl_wr  = reg_wr && reg_addr == 2'd0;
  assign clr     = ctl_wr && reg_wdata[0];
  assign st_wr   = reg_wr && reg_addr == 2'd1;

  logic push_req, pop_req, do_push, do_pop, set_ovr, set_udr;
  logic [23:0] push_data, pop_data;
  assign push_req  = IS_TX ? bus_dwr : ser_req;
  assign pop_req   = IS_TX ? ser_req : bus_drd;
  assign push_data = IS_TX ? reg_wdata[23:0] : ser_wdata;
  assign do_push   = push_req && !full;
  assign do_pop    = pop_req && !empty;
  assign set_ovr   = push_req && full;
  assign set_udr   = pop_req && empty;
  assign pop_data  = empty ? 24'd0 : mem[rd_ptr];
  assign ser_rdata = IS_TX ? pop_data : 24'd0;

  logic [CW-1:0] wr_inc, rd_inc;
  logic          wlast, rlast;
  assign wr_inc = {1'b0, wr_ptr} + CW'(1);
  assign rd_inc = {1'b0, rd_ptr} + CW'(1);
  assign wlast  = (wcol == cfg_chans_m1);
  assign rlast  = (rcol == cfg_chans_m1);

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; word_cnt <= '0; frm_cnt <= '0;
      wcol <= '0; rcol <= '0;
    end else if (clr) begin
      wr_ptr <= '0; rd_ptr <= '0; word_cnt <= '0; frm_cnt <= '0;
      wcol <= '0; rcol <= '0;
    end else begin
      if (do_push) begin
        wr_ptr <= (wr_inc == cap_words) ? '0 : wr_inc[RAM_AW-1:0];
        wcol   <= wlast ? 3'd0 : wcol + 3'd1;
      end
      if (do_pop) begin
        rd_ptr <= (rd_inc == cap_words) ? '0 : rd_inc[RAM_AW-1:0];
        rcol   <= rlast ? 3'd0 : rcol + 3'd1;
      end
      word_cnt <= word_cnt + CW'(do_push) - CW'(do_pop);
      frm_cnt  <= frm_cnt + CW'(do_push && wlast) - CW'(do_pop && rlast);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr <= 1'b0; udr <= 1'b0; irq_en <= 1'b0;
    end else begin
      ovr <= set_ovr || (st_wr ? (ovr && reg_wdata[4]) : ovr);
      udr <= set_udr || (st_wr ? (udr && reg_wdata[0]) : udr);
      if (ctl_wr) irq_en <= reg_wdata[20];
    end
  end

  logic [8:0] stat_frm;
  assign stat_frm = (frm_cnt > CW'(511)) ? 9'h1ff : frm_cnt[8:0];

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {11'd0, irq_en, 20'd0};
      2'd1:    reg_rdata = {15'd0, stat_frm, 3'd0, ovr, 3'd0, udr};
      2'd2:    reg_rdata = IS_TX ? 32'd0 : {8'd0, pop_data};
      default: reg_rdata = 32'd0;
    endcase
  end

  assign half_irq = irq_en && (IS_TX ? (frm_cnt <= half) : (frm_cnt >= half));

  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_cnt <= cap_words);

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && full && !pop_req && !clr |=> word_cnt == $past(word_cnt) && ovr);

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_req && empty && !push_req && !clr |=> word_cnt == '0 && udr);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovr && !st_wr |=> ovr);

  p_clear_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set_ovr && !set_udr |=> word_cnt == '0 && frm_cnt == '0 &&
      ovr == $past(ovr) && udr == $past(udr));

  p_irq_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en && empty |-> half_irq == IS_TX);

endmodule

// File: tb/test_audio_sample_fifo.sv
module test_audio_sample_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]  cfg_size = 3'd0, cfg_chans_m1 = 3'd1;
  logic        sel_rx = 1'b0;
  logic        bwr = 1'b0, brd = 1'b0, sreq = 1'b0;
  logic [1:0]  baddr = 2'd0;
  logic [31:0] bwdata = 32'd0;
  logic [23:0] swdata = 24'd0;
  logic [31:0] tx_rdata, rx_rdata, brdata;
  logic [23:0] tx_srdata, rx_srdata;
  logic        tx_irq, rx_irq;
  int checks = 0, fails = 0;
  logic [31:0] v;

  audio_sample_fifo #(.RAM_AW(9), .IS_TX(1'b1)) i_audio_sample_fifo (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_chans_m1(cfg_chans_m1),
    .reg_wr(bwr && !sel_rx), .reg_rd(brd && !sel_rx), .reg_addr(baddr),
    .reg_wdata(bwdata), .reg_rdata(tx_rdata), .ser_req(sreq && !sel_rx),
    .ser_wdata(swdata), .ser_rdata(tx_srdata), .half_irq(tx_irq));

  audio_sample_fifo #(.RAM_AW(9), .IS_TX(1'b0)) i_audio_sample_fifo_rx (
    .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_chans_m1(cfg_chans_m1),
    .reg_wr(bwr && sel_rx), .reg_rd(brd && sel_rx), .reg_addr(baddr),
    .reg_wdata(bwdata), .reg_rdata(rx_rdata), .ser_req(sreq && sel_rx),
    .ser_wdata(swdata), .ser_rdata(rx_srdata), .half_irq(rx_irq));

  assign brdata = sel_rx ? rx_rdata : tx_rdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bwr = 1'b1; baddr = a; bwdata = d;
    @(negedge clk); bwr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); brd = 1'b1; baddr = a; #1 d = brdata;
    @(negedge clk); brd = 1'b0;
  endtask

  task automatic spush(input logic [23:0] d);
    @(negedge clk); sreq = 1'b1; swdata = d;
    @(negedge clk); sreq = 1'b0;
  endtask

  task automatic spop(output logic [31:0] d);
    @(negedge clk); sreq = 1'b1; #1 d = {8'd0, tx_srdata};
    @(negedge clk); sreq = 1'b0;
  endtask

  task automatic clear_cfg(input logic [2:0] sz, input logic [2:0] cm1);
    wr(2'd0, 32'd1);
    wr(2'd1, 32'd0);
    cfg_size = sz; cfg_chans_m1 = cm1;
  endtask

  task automatic t_reset;
    sel_rx = 0; rd(2'd1, v); chk("R2 reset status tx", v, 32'd0);
    rd(2'd0, v); chk("R6 reset control tx", v, 32'd0);
    chk("R7 reset irq tx", {31'd0, tx_irq}, 32'd0);
    sel_rx = 1; rd(2'd1, v); chk("R2 reset status rx", v, 32'd0);
    sel_rx = 0;
  endtask

  task automatic t_tx_order;
    sel_rx = 0; clear_cfg(3'd0, 3'd1);
    wr(2'd2, 32'hFFABCDEF);
    wr(2'd2, 32'h12345600);
    rd(2'd1, v); chk("R2 one frame", v, 32'h100);
    rd(2'd2, v); chk("R9 tx data read zero", v, 32'd0);
    rd(2'd1, v); chk("R9 tx data read no pop", v, 32'h100);
    spop(v); chk("R8 first word low 24", v, 32'h00ABCDEF);
    spop(v); chk("R8 second word order", v, 32'h00345600);
  endtask

  task automatic t_three_chan;
    sel_rx = 0; clear_cfg(3'd0, 3'd2);
    wr(2'd2, 32'd7); wr(2'd2, 32'd8);
    rd(2'd1, v); chk("R2 partial frame uncounted", v, 32'h000);
    wr(2'd2, 32'd9);
    rd(2'd1, v); chk("R2 frame complete", v, 32'h100);
    wr(2'd0, 32'd1);
    for (int i = 0; i < 192; i++) wr(2'd2, i);
    rd(2'd1, v); chk("R1 three channels 64 frames", v, 32'h4000);
    wr(2'd2, 32'd999);
    rd(2'd1, v); chk("R3 overrun flag", v, 32'h4010);
    spop(v); chk("R3 first word kept", v, 32'd0);
    for (int i = 1; i < 191; i++) spop(v);
    spop(v); chk("R3 last word not overwritten", v, 32'd191);
    spop(v); chk("R4 empty pop zero", v, 32'd0);
    rd(2'd1, v); chk("R4 underrun flag", v, 32'h0011);
  endtask

  task automatic t_flags;
    sel_rx = 0;
    wr(2'd1, 32'h10);
    rd(2'd1, v); chk("R5 selective flag clear", v, 32'h10);
    wr(2'd1, 32'h0);
    rd(2'd1, v); chk("R5 flags cleared", v, 32'h0);
    @(negedge clk); bwr = 1'b1; baddr = 2'd1; bwdata = 32'd0; sreq = 1'b1;
    @(negedge clk); bwr = 1'b0; sreq = 1'b0;
    rd(2'd1, v); chk("R5 event beats clear", v, 32'h1);
  endtask

  task automatic t_clear;
    sel_rx = 0; cfg_chans_m1 = 3'd1;
    for (int i = 0; i < 4; i++) wr(2'd2, 32'hA0 + i);
    rd(2'd1, v); chk("R2 two frames", v, 32'h201);
    wr(2'd0, 32'd1);
    rd(2'd1, v); chk("R6 clear keeps flag", v, 32'h001);
    rd(2'd0, v); chk("R6 clear bit reads zero", v, 32'd0);
    spop(v); chk("R6 emptied", v, 32'd0);
    sel_rx = 1;
    spush(24'h111111); spush(24'h222222);
    rd(2'd1, v); chk("R2 rx one frame", v, 32'h100);
    @(negedge clk); bwr = 1'b1; baddr = 2'd0; bwdata = 32'd1; sreq = 1'b1; swdata = 24'h333333;
    @(negedge clk); bwr = 1'b0; sreq = 1'b0;
    rd(2'd1, v); chk("R6 clear beats serializer push", v, 32'h000);
    rd(2'd2, v); chk("R6 rx empty after clear", v, 32'd0);
    rd(2'd1, v); chk("R4 rx underrun", v, 32'h001);
    wr(2'd2, 32'h55);
    rd(2'd1, v); chk("R9 rx data write ignored", v, 32'h001);
    spush(24'hAAAAAA); spush(24'h000123);
    rd(2'd2, v); chk("R9 rx bus pop first", v, 32'h00AAAAAA);
    rd(2'd2, v); chk("R8 rx bus pop second", v, 32'h00000123);
    sel_rx = 0;
  endtask

  task automatic t_irq;
    sel_rx = 0; clear_cfg(3'd0, 3'd4);
    chk("R7 disabled irq", {31'd0, tx_irq}, 32'd0);
    wr(2'd0, 32'h100000);
    rd(2'd0, v); chk("R7 enable readback", v, 32'h100000);
    chk("R7 tx irq empty", {31'd0, tx_irq}, 32'd1);
    for (int i = 0; i < 80; i++) wr(2'd2, i);
    chk("R7 tx irq at half", {31'd0, tx_irq}, 32'd1);
    for (int i = 0; i < 5; i++) wr(2'd2, i);
    chk("R7 tx irq above half", {31'd0, tx_irq}, 32'd0);
    for (int i = 0; i < 75; i++) wr(2'd2, i);
    rd(2'd1, v); chk("R1 five channels 32 frames", v, 32'h2000);
    wr(2'd2, 32'd1);
    rd(2'd1, v); chk("R3 five channel overrun", v, 32'h2010);
    sel_rx = 1; clear_cfg(3'd0, 3'd1);
    wr(2'd0, 32'h100000);
    chk("R7 rx irq empty", {31'd0, rx_irq}, 32'd0);
    for (int i = 0; i < 126; i++) spush(i);
    chk("R7 rx irq below half", {31'd0, rx_irq}, 32'd0);
    spush(24'd1); spush(24'd2);
    chk("R7 rx irq at half", {31'd0, rx_irq}, 32'd1);
    sel_rx = 0;
  endtask

  task automatic t_size;
    sel_rx = 0; clear_cfg(3'd1, 3'd3);
    for (int i = 0; i < 512; i++) wr(2'd2, i);
    rd(2'd1, v); chk("R1 size code one four channels", v, 32'h8000);
    wr(2'd2, 32'd5);
    rd(2'd1, v); chk("R1 refused past capacity", v, 32'h8010);
    clear_cfg(3'd3, 3'd0);
    for (int i = 0; i < 512; i++) wr(2'd2, i);
    rd(2'd1, v); chk("R2 saturated count", v, 32'h1FF00);
    wr(2'd2, 32'd5);
    rd(2'd1, v); chk("R1 ram limit caps size", v, 32'h1FF10);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx_order();
    t_three_chan();
    t_flags();
    t_clear();
    t_irq();
    t_size();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule